// File: doc/BRIEF.md
# Read strobe window trainer

This block calibrates the read-strobe delay of one byte lane of a memory interface. On a start request it latches a lane number, forces that lane's 5-bit delay to zero and reads back a fixed eight-byte pattern through a single-outstanding read port. Before every read it pulses a read-FIFO reset and a clear of the sticky read-status flags. Each returned byte is checked against the pattern. The two error flags that come with the data are checked as well.

The search has two phases. The first phase raises the delay until one full pass of the pattern is clean, and that delay is recorded as the opening edge of the window. The second phase keeps re-reading the pattern and stepping the delay until some byte fails, and that delay is the closing edge. The trainer then issues one more FIFO reset, writes the midpoint of the window into the delay register, and raises a one-cycle done pulse with an ok or error result. Error is reported whenever a step would go past the top delay value.

Top module: `strobe_window_trainer`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req`, `fifo_rst`, `stat_clr` and `result_err` are low, and `dly_val` and `final_dly` are 0.
- R2: `start` seen while idle latches `lane_sel` onto `dly_lane`. The first delay write of the run (`dly_wr` high) shows `dly_val` = 0. A `start` during a run is ignored: lane, addresses and outcome do not change.
- R3: Pattern byte i (i = 0..7) is read at `rd_addr` = lane + 4*i and expected to equal, in order, FE, 11, 33, 55, 77, 99, BB, DD (hex).
- R4: Every read request is preceded by exactly one `fifo_rst` pulse and one `stat_clr` pulse, and `rd_req` is a one-cycle pulse with at most one read outstanding.
- R5: A read fails if the byte differs from the pattern, if `rd_masked` or `rd_dummy` is high with the response, or if no `rd_valid` arrives within RSP_TIMEOUT cycles of waiting.
- R6: In the opening phase, any failure raises the delay by one and restarts at byte 0. Eight clean bytes in a row record the current delay as the window start.
- R7: The closing phase starts at the window start and reads the pattern. The first failure fixes the current delay as the window end, and eight clean bytes raise the delay by one and restart at byte 0.
- R8: On an ok outcome, one extra `fifo_rst` pulse is issued after the last read, and the final delay is start + ((end - start) >> 1). This value appears on both `dly_val` and `final_dly`.
- R9: A step requested while the delay is 31 ends the run with `result_err` = 1 (1 = error, 0 = ok) and the delay left at 31.
- R10: `done` is high for exactly one cycle per run. `result_err` and `final_dly` keep their values until the next accepted start.
- R11: `dly_val` changes only in a cycle in which `dly_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| start | input | 1 | begin training of the lane on `lane_sel` |
| lane_sel | input | LANE_W | lane to train |
| busy | output | 1 | run in progress (includes the done cycle) |
| done | output | 1 | one-cycle completion pulse |
| result_err | output | 1 | 1 = error, 0 = ok |
| final_dly | output | 5 | delay left in the lane at the end of the run |
| dly_lane | output | LANE_W | lane whose delay line is being driven |
| dly_val | output | 5 | current delay setting of that lane |
| dly_wr | output | 1 | delay-line write strobe, high when `dly_val` takes a new value |
| fifo_rst | output | 1 | read FIFO reset pulse |
| stat_clr | output | 1 | clear of the sticky read-status flags |
| rd_req | output | 1 | read request pulse |
| rd_addr | output | ADDR_W | byte address of the read |
| rd_valid | input | 1 | read response strobe |
| rd_data | input | 8 | returned byte |
| rd_masked | input | 1 | response carried masked data |
| rd_dummy | input | 1 | response carried dummy data |

## Verification
The memory model decides pass or fail from the live delay, so the bench can target window edges. It uses a window at delay 0, a one-step window, a window that ends at 30, a window that reaches 31, and no window at all. A trainer that stopped the closing phase one step late or early, or that rounded the midpoint up, would leave a final delay one off from the value computed in the bench. A trainer that wrapped the 5-bit delay instead of saturating would run on past 31 and never report an error. Failures arrive in four forms, including a dropped response, and fall on varying byte positions. A design that ignored a flag, hung on a missing response, or did not restart at byte 0 would issue a read sequence that departs from the queued one. A start pulsed mid-run must leave the addresses on the first lane.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int DLY_W   = 5;
  localparam int PAT_LEN = 8;
  localparam int IDX_W   = $clog2(PAT_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_ZERO, S_PREP, S_REQ, S_WAIT, S_STEP, S_FIN, S_DONE
  } swt_state_e;

  typedef enum logic {
    PH_OPEN,
    PH_CLOSE
  } swt_phase_e;
endpackage

// File: rtl/swt_pattern_rom.sv
module swt_pattern_rom #(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       pat_byte
);
  // idle-safe decode; first byte breaks the odd-byte rhythm
  always_comb begin
    case (idx)
      3'd0:    pat_byte = 8'hFE;
      3'd1:    pat_byte = 8'h11;
      3'd2:    pat_byte = 8'h33;
      3'd3:    pat_byte = 8'h55;
      3'd4:    pat_byte = 8'h77;
      3'd5:    pat_byte = 8'h99;
      3'd6:    pat_byte = 8'hBB;
      default: pat_byte = 8'hDD;
    endcase
  end
endmodule

// File: rtl/swt_rsp_timer.sv
module swt_rsp_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/swt_delay_reg.sv
module swt_delay_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_zero,
  input  logic         op_step,
  input  logic         op_centre,
  input  logic [W-1:0] win_lo,
  output logic [W-1:0] val,
  output logic         wr,
  output logic         at_max,
  output logic [W-1:0] centre
);
  logic [W-1:0] span;

  assign at_max = &val;
  assign span   = val - win_lo;
  assign centre = win_lo + (span >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      val <= '0;
      wr  <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (op_zero) begin
        val <= '0;
        wr  <= 1'b1;
      end else if (op_step && !at_max) begin
        val <= val + 1'b1;
        wr  <= 1'b1;
      end else if (op_centre) begin
        val <= centre;
        wr  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/strobe_window_trainer.sv
module strobe_window_trainer
  import swt_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int ADDR_W      = 8,
  parameter int RSP_TIMEOUT = 16,
  localparam int LANE_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LANE_W-1:0] lane_sel,
  output logic              busy,
  output logic              done,
  output logic              result_err,
  output logic [DLY_W-1:0]  final_dly,
  output logic [LANE_W-1:0] dly_lane,
  output logic [DLY_W-1:0]  dly_val,
  output logic              dly_wr,
  output logic              fifo_rst,
  output logic              stat_clr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  input  logic              rd_masked,
  input  logic              rd_dummy
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAT_LEN - 1);

  swt_state_e        st, st_n;
  swt_phase_e        ph;
  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] lane_q;
  logic [DLY_W-1:0]  lo_q;
  logic [DLY_W-1:0]  centre;
  logic [7:0]        exp_byte;
  logic              at_max, tmo;
  logic              rsp_got, rsp_bad, last_byte;
  logic [ADDR_W-1:0] addr_cur;

  swt_pattern_rom #(.IDX_W(IDX_W)) u_pat (
    .idx      (idx),
    .pat_byte (exp_byte)
  );

  swt_rsp_timer #(.LIMIT(RSP_TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (st == S_REQ),
    .run     (st == S_WAIT),
    .expired (tmo)
  );

  swt_delay_reg #(.W(DLY_W)) u_dly (
    .clk       (clk),
    .rst       (rst),
    .op_zero   (st == S_ZERO),
    .op_step   (st == S_STEP),
    .op_centre (st == S_FIN),
    .win_lo    (lo_q),
    .val       (dly_val),
    .wr        (dly_wr),
    .at_max    (at_max),
    .centre    (centre)
  );

  assign rsp_got   = rd_valid || tmo;
  assign rsp_bad   = !rd_valid || (rd_data != exp_byte) || rd_masked || rd_dummy;
  assign last_byte = (idx == IDX_LAST);
  assign addr_cur  = ADDR_W'(lane_q) + ADDR_W'({idx, 2'b00});
  assign dly_lane  = lane_q;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE: if (start) st_n = S_ZERO;
      S_ZERO: st_n = S_PREP;
      S_PREP: st_n = S_REQ;
      S_REQ:  st_n = S_WAIT;
      S_WAIT: begin
        if (rsp_got) begin
          if (ph == PH_OPEN) st_n = rsp_bad ? S_STEP : S_PREP;
          else if (rsp_bad)  st_n = S_FIN;
          else               st_n = last_byte ? S_STEP : S_PREP;
        end
      end
      S_STEP: st_n = at_max ? S_DONE : S_PREP;
      S_FIN:  st_n = S_DONE;
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ph         <= PH_OPEN;
      idx        <= '0;
      lane_q     <= '0;
      lo_q       <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result_err <= 1'b0;
      final_dly  <= '0;
      fifo_rst   <= 1'b0;
      stat_clr   <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
    end else begin
      st       <= st_n;
      busy     <= (st_n != S_IDLE);
      done     <= (st_n == S_DONE);
      fifo_rst <= (st_n == S_PREP) || (st_n == S_FIN);
      stat_clr <= (st_n == S_PREP);
      rd_req   <= (st_n == S_REQ);
      if (st_n == S_REQ) rd_addr <= addr_cur;
      case (st)
        S_IDLE: if (start) begin
          lane_q <= lane_sel;
          ph     <= PH_OPEN;
          idx    <= '0;
        end
        S_WAIT: if (rsp_got && !rsp_bad) begin
          if (ph == PH_OPEN && last_byte) begin
            lo_q <= dly_val;
            ph   <= PH_CLOSE;
            idx  <= '0;
          end else if (!last_byte) begin
            idx <= idx + 1'b1;
          end
        end
        S_STEP: begin
          idx <= '0;
          if (at_max) begin
            result_err <= 1'b1;
            final_dly  <= dly_val;
          end
        end
        S_FIN: begin
          result_err <= 1'b0;
          final_dly  <= centre;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int DW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          result_err,
  input logic [DW-1:0] final_dly,
  input logic [DW-1:0] dly_val,
  input logic          dly_wr,
  input logic          fifo_rst,
  input logic          stat_clr,
  input logic          rd_req
);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |=> ($stable(final_dly) && $stable(result_err)));

  assert_delay_strobed_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(dly_val) |-> dly_wr);

  assert_single_req_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_prep_before_read_R4: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(fifo_rst) && $past(stat_clr)));

  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> busy);

  assert_error_at_top_R9: assert property (@(posedge clk) disable iff (rst)
    (done && result_err) |-> (&dly_val));
endmodule

bind strobe_window_trainer swt_checker #(.DW(swt_pkg::DLY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .result_err (result_err),
  .final_dly  (final_dly),
  .dly_val    (dly_val),
  .dly_wr     (dly_wr),
  .fifo_rst   (fifo_rst),
  .stat_clr   (stat_clr),
  .rd_req     (rd_req)
);

// File: tb/sim_strobe_window_trainer.sv
`timescale 1ns/1ps
module sim_strobe_window_trainer;
  localparam int NL = 4;
  localparam int AW = 8;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] lane_sel = '0;
  logic busy, done, result_err, dly_wr, fifo_rst, stat_clr, rd_req;
  logic [4:0] final_dly, dly_val;
  logic [1:0] dly_lane;
  logic [AW-1:0] rd_addr;
  logic rd_valid = 1'b0, rd_masked = 1'b0, rd_dummy = 1'b0;
  logic [7:0] rd_data = '0;

  always #2.5 clk = ~clk;

  strobe_window_trainer #(.NUM_LANES(NL), .ADDR_W(AW), .RSP_TIMEOUT(TMO)) u0 (
    .clk(clk), .rst(rst), .start(start), .lane_sel(lane_sel), .busy(busy),
    .done(done), .result_err(result_err), .final_dly(final_dly),
    .dly_lane(dly_lane), .dly_val(dly_val), .dly_wr(dly_wr),
    .fifo_rst(fifo_rst), .stat_clr(stat_clr), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_masked(rd_masked), .rd_dummy(rd_dummy)
  );

  int n_chk = 0, n_fail = 0;
  bit [7:0] pat [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};
  int lane_g = 0, lo_g = 0, hi_g = -1;
  int exp_q[$];
  bit armed = 0, first_wr = 0;
  int fr_cnt = 0, sc_cnt = 0, resp_cnt = 0, prev_dly = 0;
  logic [7:0] r_data;
  logic r_m, r_d;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic bit fails(int d, int i);
    return !(d >= lo_g && d <= hi_g) && ((d + i) % 3 == 0);
  endfunction

  // memory / delay-line model and per-clock reference comparison
  always @(negedge clk) begin
    rd_valid = 1'b0; rd_masked = 1'b0; rd_dummy = 1'b0;
    if (armed) begin
      if (resp_cnt > 0) begin
        resp_cnt--;
        if (resp_cnt == 0) begin
          rd_valid = 1'b1; rd_data = r_data; rd_masked = r_m; rd_dummy = r_d;
        end
      end
      if (fifo_rst) fr_cnt++;
      if (stat_clr) sc_cnt++;
      if (int'(dly_val) != prev_dly) chk(dly_wr, "R11 delay moved without strobe", int'(dly_wr), 1);
      prev_dly = int'(dly_val);
      if (dly_wr && first_wr) begin
        chk(dly_val == 0, "R2 first delay write", int'(dly_val), 0);
        first_wr = 0;
      end
      if (rd_req) begin
        chk(fr_cnt == 1 && sc_cnt == 1, "R4 resets before read", fr_cnt * 10 + sc_cnt, 11);
        fr_cnt = 0; sc_cnt = 0;
        if (exp_q.size() == 0) chk(0, "R6 R7 unexpected extra read", int'(rd_addr), -1);
        else begin
          int e, d, i;
          e = exp_q.pop_front();
          chk(int'(dly_val) == (e >> 8), "R6 R7 delay at read", int'(dly_val), e >> 8);
          chk(int'(rd_addr) == (e & 255), "R3 read address", int'(rd_addr), e & 255);
          d = int'(dly_val);
          i = ((int'(rd_addr) - lane_g) >> 2) & 7;
          r_data = pat[i]; r_m = 0; r_d = 0; resp_cnt = 1 + (i % 3);
          if (fails(d, i)) begin  // R5 failure forms
            case (d % 4)
              0: r_data = ~pat[i];
              1: r_m = 1;
              2: r_d = 1;
              default: resp_cnt = 0;
            endcase
          end
        end
      end
    end
  end

  task automatic run(int lane, int lo, int hi, int intr_lane, string tag);
    int d, st, en, cyc, fin;
    bit err, ok;
    lo_g = lo; hi_g = hi; lane_g = lane;
    exp_q.delete();
    d = 0; err = 0; st = 0; en = 0;
    forever begin
      ok = 1;
      for (int i = 0; i < 8; i++) begin
        exp_q.push_back(d * 256 + lane + 4 * i);
        if (fails(d, i)) begin ok = 0; break; end
      end
      if (ok) break;
      if (d == 31) begin err = 1; break; end
      d++;
    end
    if (!err) begin
      st = d;
      forever begin
        ok = 1;
        for (int i = 0; i < 8; i++) begin
          exp_q.push_back(d * 256 + lane + 4 * i);
          if (fails(d, i)) begin ok = 0; break; end
        end
        if (!ok) begin en = d; break; end
        if (d == 31) begin err = 1; break; end
        d++;
      end
    end
    fin = err ? 31 : st + ((en - st) >> 1);
    @(negedge clk);
    fr_cnt = 0; sc_cnt = 0; first_wr = 1;
    start = 1; lane_sel = 2'(lane);
    @(negedge clk);
    start = 0;
    if (intr_lane >= 0) begin
      repeat (20) @(negedge clk);
      start = 1; lane_sel = 2'(intr_lane);
      @(negedge clk);
      start = 0;
    end
    cyc = 0;
    while (!done && cyc < 40000) begin @(negedge clk); cyc++; end
    if (!done) begin chk(0, {"R10 no done ", tag}, 0, 1); return; end
    chk(int'(dly_lane) == lane, {"R2 lane latched ", tag}, int'(dly_lane), lane);
    chk(result_err == err, {"R9 result ", tag}, int'(result_err), int'(err));
    chk(int'(final_dly) == fin, {"R8 final delay ", tag}, int'(final_dly), fin);
    chk(int'(dly_val) == fin, {"R8 delay line ", tag}, int'(dly_val), fin);
    chk(exp_q.size() == 0, {"R6 R7 read count ", tag}, exp_q.size(), 0);
    if (!err) chk(fr_cnt == 1, {"R8 closing FIFO reset ", tag}, fr_cnt, 1);
    @(negedge clk);
    chk(!done, {"R10 done width ", tag}, int'(done), 0);
    repeat (8) @(negedge clk);
    chk(int'(final_dly) == fin && result_err == err, {"R10 hold ", tag}, int'(final_dly), fin);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !rd_req && !fifo_rst && !stat_clr && !result_err,
        "R1 reset controls", int'(busy), 0);
    chk(dly_val == 0 && final_dly == 0, "R1 reset delay", int'(dly_val), 0);
    armed = 1;
    run(0, 5, 12, 2, "win5_12_intr");   // R2 start while busy ignored
    run(3, 0, 3, -1, "win0_3");
    run(1, 17, 17, -1, "single17");
    run(2, 30, 30, -1, "win30");
    run(1, 20, 31, -1, "reach31");      // R9 closing phase saturates
    run(2, 40, 50, -1, "nowindow");     // R9 opening phase saturates
    run(3, 9, 26, -1, "wide");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule